// File: doc/BRIEF.md
# Clock-Aligned Run-Start Sync Generator

This block lives in a fast clock domain (4 ns period) and issues the single synchronization pulse that starts a data-taking run. The pulse must land on a fast-clock cycle that also coincides with an edge of a slower system clock. That slower clock runs at exactly one sixth of the fast rate (24 ns period). If the pulse could fall on any of the six fast cycles inside a slow period, each run would start with a different phase relation between the two time bases. Holding the pulse until a common edge makes that relation the same in every run.

A marker input, already sampled into the fast domain, flags the fast cycle that carries a slow-clock edge. The block keeps a modulo-six phase count. Every marker forces that count to phase zero. Software raises a request at any moment. The block latches it, reports busy, and releases a one-cycle pulse on the next phase-zero cycle. No pulse is possible until a marker has set the phase reference.

Top module: `sync_align_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy` and `sync_pulse` are 0.
- R2: A cycle is aligned when `slow_edge` is 1 in it, or when it falls a whole multiple of 6 cycles after the most recent cycle with `slow_edge` at 1. No other cycle is aligned.
- R3: `busy` rises on the cycle after a request cycle (a cycle with `sync_req` at 1 while `busy` is 0). It stays 1 up to and including the cycle of the pulse, and is 0 on the cycle after the pulse.
- R4: After a request in cycle r, `sync_pulse` is 1 on the first aligned cycle strictly later than r. That includes the case where cycle r is itself aligned.
- R5: `sync_pulse` is exactly one cycle wide. A request made while `busy` is 1, including the pulse cycle itself, produces no further pulse and does not extend `busy`.
- R6: After reset, no pulse occurs before the first cycle with `slow_edge` at 1. A request made earlier keeps `busy` at 1 and fires on that first marker cycle.
- R7: A marker arriving at a cycle that is not a multiple of 6 from the previous marker realigns the phase. Later aligned cycles are counted from the new marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_req | input | 1 | Software request for a run-start sync |
| slow_edge | input | 1 | High on the fast cycle that carries a slow-clock edge |
| sync_pulse | output | 1 | One-cycle aligned sync pulse |
| busy | output | 1 | A request is pending and the pulse has not yet been issued |

## Verification
Two events can fall in the same cycle: a new request and the release of a pending pulse. A request in the pulse cycle must be absorbed and must not re-arm the block. The bench provokes this by placing a second request on every cycle from the one after the first request up to the exact pulse cycle. It judges the result by the absence of a second pulse and by `busy` dropping the cycle after the pulse. A second collision is a request made in an aligned cycle itself. That request must wait a full six cycles, and the bench's sweep of every request offset against every marker offset checks it.

// File: rtl/sync_align_pkg.sv
// Package: shared constants for the aligned sync generator.
// Assumes: the fast/slow period ratio is a fixed integer of at least 2.
package sync_align_pkg;
    localparam int unsigned SA_DEF_RATIO = 6;

    // Width that can hold a phase index 0 .. ratio-1.
    function automatic int unsigned sa_phase_width(input int unsigned ratio);
        return (ratio <= 2) ? 1 : $clog2(ratio);
    endfunction
endpackage

// File: rtl/sa_phase_track.sv
// Module: modulo-RATIO phase tracker locked to a slow-edge marker.
// The marker cycle is phase 0. The count then advances by one per fast
// cycle and wraps after RATIO-1. The block is flagged locked once any
// marker has been seen since reset.
// Assumes: slow_edge is synchronous to clk and free of metastability.
module sa_phase_track #(
    parameter int unsigned RATIO = sync_align_pkg::SA_DEF_RATIO,
    localparam int unsigned PW   = sync_align_pkg::sa_phase_width(RATIO)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_edge,
    output logic aligned
);
    localparam logic [PW-1:0] LAST_PH = PW'(RATIO - 1);

    logic [PW-1:0] ph_q;
    logic [PW-1:0] ph_eff;
    logic          locked_q;
    logic          locked_eff;

    // Marker overrides the stored count: this cycle is phase 0.
    always_comb begin
        ph_eff     = slow_edge ? '0 : ph_q;
        locked_eff = locked_q | slow_edge;
        aligned    = locked_eff && (ph_eff == '0);
    end

    // Advance the phase with wrap, and remember that a marker was seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= '0;
            locked_q <= 1'b0;
        end else begin
            ph_q     <= (ph_eff == LAST_PH) ? '0 : ph_eff + PW'(1);
            locked_q <= locked_eff;
        end
    end
endmodule

// File: rtl/sa_req_hold.sv
// Module: request latch that releases one pulse on an aligned cycle.
// A request is captured at the clock edge. Requests arriving while one is
// pending, or in the release cycle, are absorbed.
// Assumes: aligned is high on at most one cycle per slow period.
module sa_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_req,
    input  logic aligned,
    output logic pending,
    output logic fire
);
    logic pend_q;

    // Release when a latched request meets an aligned cycle.
    always_comb begin
        fire    = pend_q & aligned;
        pending = pend_q;
    end

    // Latch request; clear on release (same-cycle requests are dropped).
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (fire)
            pend_q <= 1'b0;
        else if (sync_req)
            pend_q <= 1'b1;
    end
endmodule

// File: rtl/sync_align_gen.sv
// Module: top of the aligned run-start sync generator.
// Issues a one-cycle sync pulse only on a fast cycle that coincides with
// a slow-clock edge, at a fixed RATIO:1 period ratio.
// Assumes: slow_edge is pre-sampled into the fast domain; clocks are
// generated and distributed elsewhere.
module sync_align_gen #(
    parameter int unsigned RATIO = sync_align_pkg::SA_DEF_RATIO
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_req,
    input  logic slow_edge,
    output logic sync_pulse,
    output logic busy
);
    logic aligned;

    // Phase reference derived from the slow-edge marker.
    sa_phase_track #(.RATIO(RATIO)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_edge (slow_edge),
        .aligned   (aligned)
    );

    // Request capture and aligned release.
    sa_req_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_req (sync_req),
        .aligned  (aligned),
        .pending  (busy),
        .fire     (sync_pulse)
    );
endmodule

// File: rtl/sync_align_gen_chk.sv
// Checker: temporal properties of the aligned sync generator, bound to
// the top module. Keeps its own record of whether a marker was seen.
module sync_align_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic sync_req,
    input logic slow_edge,
    input logic sync_pulse,
    input logic busy
);
    logic seen_q;

    // Track whether any marker has occurred since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (slow_edge) seen_q <= 1'b1;
    end

    AST_PULSE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> busy); // R3
    AST_REQ_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && !busy) |=> busy); // R3
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sync_pulse) |=> busy); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse); // R5
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !busy); // R5
    AST_MARKER_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && slow_edge) |-> sync_pulse); // R2
    AST_NO_PULSE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> (seen_q || slow_edge)); // R6
endmodule

bind sync_align_gen sync_align_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_req   (sync_req),
    .slow_edge  (slow_edge),
    .sync_pulse (sync_pulse),
    .busy       (busy)
);

// File: tb/sync_align_gen_tb.sv
// Bench: sweeps marker offsets and request cycles; expected pulse and
// busy cycles are computed arithmetically from the requirements.
module sync_align_gen_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_req = 1'b0;
    logic slow_edge = 1'b0;
    logic sync_pulse;
    logic busy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int  m0, xm, r1, r2;
    bit  mk_on;

    sync_align_gen u_dut (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req),
        .slow_edge(slow_edge), .sync_pulse(sync_pulse), .busy(busy)
    );

    always #5 clk = ~clk;

    // Marker pattern: period 6 from m0; an extra marker at xm restarts it.
    function automatic bit is_marker(input int c);
        if (xm >= 0 && c == xm) return 1'b1;
        if (!mk_on || c < m0) return 1'b0;
        if (xm >= 0 && c > xm) return ((c - xm) % 6) == 0;
        return ((c - m0) % 6) == 0;
    endfunction

    // R2: aligned iff a multiple of 6 after the latest marker.
    function automatic bit aligned_at(input int c);
        for (int m = c; m >= 0; m--)
            if (is_marker(m)) return ((c - m) % 6) == 0;
        return 1'b0;
    endfunction

    function automatic int first_after(input int r, input int lim);
        for (int c = r + 1; c < lim; c++)
            if (aligned_at(c)) return c;
        return -1;
    endfunction

    task automatic check(input string req, input bit act, input bit exp, input int c);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0b expected %0b", req, c, act, exp);
        end
    endtask

    // Reset, then run n cycles of the current scenario checking each one.
    task automatic run(input string rp, input string rb, input int n);
        int p1, p2;
        bit ep, eb;
        @(negedge clk);
        rst_n = 1'b0; sync_req = 1'b0; slow_edge = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        check("R1 busy in reset", busy, 1'b0, -1);
        check("R1 pulse in reset", sync_pulse, 1'b0, -1);
        p1 = (r1 >= 0) ? first_after(r1, n) : -1;
        p2 = (p1 >= 0 && r2 > p1) ? first_after(r2, n) : -1;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            rst_n     = 1'b1;
            sync_req  = (c == r1) || (c == r2);
            slow_edge = is_marker(c);
            #2;
            ep = (p1 >= 0 && c == p1) || (p2 >= 0 && c == p2);
            if (r1 < 0)       eb = 1'b0;
            else if (p1 < 0)  eb = (c > r1);
            else              eb = (c > r1 && c <= p1);
            if (p2 >= 0 && c > r2 && c <= p2) eb = 1'b1;
            if (r2 > p1 && p1 >= 0 && p2 < 0 && c > r2) eb = 1'b1;
            check(rp, sync_pulse, ep, c);
            check(rb, busy, eb, c);
            if (c == 0) check("R1 first cycle busy", busy, 1'b0, c);
        end
        sync_req = 1'b0;
    endtask

    initial begin
        // R2/R4: every marker offset against every request cycle.
        mk_on = 1; xm = -1; r2 = -1;
        for (int m = 0; m < 6; m++)
            for (int r = 0; r < 12; r++) begin
                m0 = m; r1 = r;
                run("R4 R2 pulse sweep", "R3 busy sweep", 30);
            end
        // R5: second request at every cycle up to and past the pulse cycle.
        m0 = 2; r1 = 3;
        for (int r = 4; r < 12; r++) begin
            r2 = r;
            run("R5 absorb pulse", "R5 absorb busy", 30);
        end
        // R6: no marker at all -> no pulse, busy held.
        mk_on = 0; m0 = 0; r1 = 2; r2 = -1;
        run("R6 no marker pulse", "R6 no marker busy", 40);
        // R6: markers start late; early request fires on first marker.
        mk_on = 1; m0 = 20;
        for (int r = 0; r < 4; r++) begin
            r1 = r;
            run("R6 late lock pulse", "R6 late lock busy", 40);
        end
        // R7: off-phase marker at 9 realigns the phase.
        m0 = 0; xm = 9;
        for (int r = 7; r < 15; r++) begin
            r1 = r;
            run("R7 realign pulse", "R7 realign busy", 36);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule